// File: doc/BRIEF.md
# Rotated Immediate Encoder and Checker

This block decides whether a 32-bit constant fits a 12-bit rotated-immediate field. Such a field holds an 8-bit payload and a 4-bit rotate count, and it stands for the payload rotated right by twice the count. For each strobed constant the block searches all sixteen even rotations. It reports whether the constant can be encoded and, if it can, gives the 12-bit code. The same search runs on the bitwise inverse of the constant, and that result has its own flag, so a code generator can pick a complement-move form instead.

A separate decode port expands any 12-bit code back into its 32-bit value. This lets the caller, or a bench, check that an encoding round-trips. Results are registered and appear one clock after the input strobe, together with an output valid pulse.

Top module: `rimm_codec`

## Requirements
- R1: A code carries the rotate count in bits 11:8 and the payload in bits 7:0. It stands for the payload, zero-extended to 32 bits, rotated right by twice the count, so the rotations are 0, 2, ..., 30.
- R2: A constant equal to the expansion of some code sets `direct_ok`. Examples are 0xFF (code 0x0FF), 0xFF000 (0xAFF), 0xF000000F (0x2FF), 0xF200 (0xCF2), 0x3FC (0xFFF) and 0x7F00 (0xC7F).
- R3: A constant whose set bits do not all fit inside one 8-bit window at an even rotation clears `direct_ok` and drives `direct_code` to 0x000. Examples are 0x101, 0xFF04, 0x1FE and 0x1FF. The same rule applies to `inv_ok` and `inv_code`.
- R4: When more than one code is valid, the code with the smallest rotate count is given. For 0x3F0 this is 0xE3F, not 0xFFC.
- R5: The constant zero is legal and encodes as 0x000.
- R6: The inverse path reports `inv_ok` and `inv_code` for the bitwise inverse of the constant, using the same rules as R2 to R5. For 0xFFFFFF00, `inv_ok` is 1 and `inv_code` is 0x0FF, while `direct_ok` is 0.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The result fields are updated only on a strobe.
- R8: Reset is synchronous and active-high. It clears `out_valid`, both flags and both codes, even when `in_valid` is high at the same time.
- R9: Whenever `direct_ok` is set, decoding `direct_code` gives back the input constant exactly.
- R10: `dec_word` shows the expansion of `dec_code` one clock after it is applied, whatever the value of `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe for `in_word` |
| in_word | input | 32 | Constant to encode |
| dec_code | input | 12 | Code to expand |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| direct_ok | output | 1 | Constant is encodable |
| direct_code | output | 12 | Code for the constant, zero if illegal |
| inv_ok | output | 1 | Inverse of the constant is encodable |
| inv_code | output | 12 | Code for the inverse, zero if illegal |
| dec_word | output | 32 | Expansion of `dec_code` |

## Verification
The hardest behaviour to reach from the ports is the tie-break. Random 32-bit constants are almost never encodable, and ones with several valid encodings are rarer still. The bench therefore produces its stimulus from codes: it expands every one of the 4096 codes and feeds the result back as a constant. This sweeps every payload at every rotation, including all the payloads whose low bit pairs are zero and so have several valid codes. It also feeds the inverse of every expansion, which drives the complement path through all of its legal cases. An independent mask-based model in the bench gives the expected minimal code for each one.

// File: rtl/rimm_pkg.sv
package rimm_pkg;
  parameter int WORD_W = 32;
  parameter int PAY_W  = 8;
  parameter int ROT_W  = 4;

  localparam int CODE_W = ROT_W + PAY_W;
  localparam int N_ROT  = 1 << ROT_W;
  localparam int STEP   = WORD_W / N_ROT;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [ROT_W-1:0]  rot_t;
  typedef logic [PAY_W-1:0]  pay_t;

  // Rotate right by k positions (k taken modulo the word width).
  function automatic word_t rotr(word_t v, int unsigned k);
    logic [2*WORD_W-1:0] dbl;
    dbl = {v, v} >> (k % WORD_W);
    return dbl[WORD_W-1:0];
  endfunction

  // Rotate left by k positions.
  function automatic word_t rotl(word_t v, int unsigned k);
    return rotr(v, (WORD_W - (k % WORD_W)) % WORD_W);
  endfunction

  // Expand a code into the word it stands for.
  function automatic word_t expand(code_t c);
    word_t p;
    p = {{(WORD_W-PAY_W){1'b0}}, c[PAY_W-1:0]};
    return rotr(p, STEP * int'(c[CODE_W-1:PAY_W]));
  endfunction
endpackage

// File: rtl/rimm_search.sv
module rimm_search
  import rimm_pkg::*;
(
  input  word_t value,
  output logic  found,
  output code_t code
);
  logic [N_ROT-1:0] fit;
  pay_t             cand [N_ROT];

  // One window test per even rotation.
  for (genvar r = 0; r < N_ROT; r++) begin : g_rot
    word_t back;
    assign back     = rotl(value, STEP * r);
    assign fit[r]   = (back[WORD_W-1:PAY_W] == '0);
    assign cand[r]  = back[PAY_W-1:0];
  end

  // Scan from the top rotation downwards so the smallest fitting one wins.
  always_comb begin
    found = 1'b0;
    code  = '0;
    for (int r = N_ROT - 1; r >= 0; r--) begin
      if (fit[r]) begin
        found = 1'b1;
        code  = {rot_t'(r), cand[r]};
      end
    end
  end
endmodule

// File: rtl/rimm_expand.sv
module rimm_expand
  import rimm_pkg::*;
(
  input  code_t code,
  output word_t word
);
  assign word = expand(code);
endmodule

// File: rtl/rimm_codec.sv
module rimm_codec
  import rimm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [CODE_W-1:0] dec_code,
  output logic              out_valid,
  output logic              direct_ok,
  output logic [CODE_W-1:0] direct_code,
  output logic              inv_ok,
  output logic [CODE_W-1:0] inv_code,
  output logic [WORD_W-1:0] dec_word
);
  // Named internal events.
  word_t inv_word;
  logic  dir_hit, inv_hit;
  code_t dir_code_n, inv_code_n;
  word_t dec_word_n;

  assign inv_word = ~in_word;

  rimm_search u_dir (.value(in_word),  .found(dir_hit), .code(dir_code_n));
  rimm_search u_inv (.value(inv_word), .found(inv_hit), .code(inv_code_n));
  rimm_expand u_dec (.code(dec_code),  .word(dec_word_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      direct_ok   <= 1'b0;
      direct_code <= '0;
      inv_ok      <= 1'b0;
      inv_code    <= '0;
      dec_word    <= '0;
    end else begin
      out_valid <= in_valid;
      dec_word  <= dec_word_n;
      if (in_valid) begin
        direct_ok   <= dir_hit;
        direct_code <= dir_code_n;
        inv_ok      <= inv_hit;
        inv_code    <= inv_code_n;
      end
    end
  end
endmodule

// File: rtl/rimm_codec_chk.sv
module rimm_codec_chk
  import rimm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word,
  input logic [CODE_W-1:0] dec_code,
  input logic              out_valid,
  input logic              direct_ok,
  input logic [CODE_W-1:0] direct_code,
  input logic              inv_ok,
  input logic [CODE_W-1:0] inv_code,
  input logic [WORD_W-1:0] dec_word
);
  localparam word_t PAY_MASK = word_t'({PAY_W{1'b1}});

  // True when some rotation below rot already holds every set bit of w.
  function automatic logic lower_fits(word_t w, rot_t rot);
    logic hit;
    hit = 1'b0;
    for (int r = 0; r < N_ROT; r++) begin
      if (r < int'(rot) && ((w & ~rotr(PAY_MASK, STEP * r)) == '0)) hit = 1'b1;
    end
    return hit;
  endfunction

  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R3
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !direct_ok) |-> (direct_code == '0));
  // R3
  inv_illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !inv_ok) |-> (inv_code == '0));
  // R9
  round_trip_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && direct_ok) |-> (expand(direct_code) == $past(in_word)));
  // R6
  inv_round_trip_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && inv_ok) |-> (expand(inv_code) == ~$past(in_word)));
  // R4
  min_rot_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && direct_ok) |-> !lower_fits($past(in_word), direct_code[CODE_W-1:PAY_W]));
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !direct_ok && !inv_ok && direct_code == '0 && inv_code == '0));
  // R10
  decode_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (dec_word == expand($past(dec_code))));
endmodule

bind rimm_codec rimm_codec_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
  .dec_code(dec_code), .out_valid(out_valid), .direct_ok(direct_ok),
  .direct_code(direct_code), .inv_ok(inv_ok), .inv_code(inv_code),
  .dec_word(dec_word)
);

// File: tb/rimm_codec_bench.sv
`timescale 1ns/100ps
module rimm_codec_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_word;
  logic [11:0] dec_code;
  logic        out_valid, direct_ok, inv_ok;
  logic [11:0] direct_code, inv_code;
  logic [31:0] dec_word;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  rimm_codec u_rimm_codec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .dec_code(dec_code), .out_valid(out_valid), .direct_ok(direct_ok),
    .direct_code(direct_code), .inv_ok(inv_ok), .inv_code(inv_code),
    .dec_word(dec_word)
  );

  // Bit-by-bit right rotation of the payload: out[i] = p[(i+s) mod 32].
  function automatic logic [31:0] ref_expand(logic [11:0] c);
    logic [31:0] p, o;
    int s;
    p = {24'b0, c[7:0]};
    s = 2 * int'(c[11:8]);
    for (int i = 0; i < 32; i++) o[i] = p[(i + s) % 32];
    return o;
  endfunction

  // Mask test per rotation, lowest rotation first.
  task automatic ref_encode(input logic [31:0] w, output logic ok, output logic [11:0] code);
    logic [31:0] mask;
    logic [7:0]  p;
    ok = 1'b0;
    code = 12'h000;
    for (int r = 0; r < 16; r++) begin
      mask = ref_expand({r[3:0], 8'hFF});
      if (!ok && ((w & ~mask) == 32'h0)) begin
        for (int j = 0; j < 8; j++) p[j] = w[(j + 32 - 2 * r) % 32];
        ok = 1'b1;
        code = {r[3:0], p};
      end
    end
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one constant and code at a falling edge, check at the next one.
  task automatic run_one(input logic [31:0] w, input logic [11:0] c);
    logic eok, iok;
    logic [11:0] ecode, icode;
    ref_encode(w, eok, ecode);
    ref_encode(~w, iok, icode);
    in_valid = 1'b1; in_word = w; dec_code = c;
    @(negedge clk);
    check("R7", "out_valid", {31'b0, out_valid}, 32'h1);
    check(eok ? "R2" : "R3", "direct_ok", {31'b0, direct_ok}, {31'b0, eok});
    check("R4", "direct_code", {20'b0, direct_code}, {20'b0, ecode});
    check("R6", "inv_ok", {31'b0, inv_ok}, {31'b0, iok});
    check("R6", "inv_code", {20'b0, inv_code}, {20'b0, icode});
    check("R10", "dec_word", dec_word, ref_expand(c));
    if (direct_ok) check("R9", "round trip", ref_expand(direct_code), w);
    if (inv_ok)    check("R6", "inverse round trip", ref_expand(inv_code), ~w);
  endtask

  task automatic corner(input string req, input logic [31:0] w, input logic eok, input logic [11:0] ecode);
    run_one(w, ecode);
    check(req, "corner flag", {31'b0, direct_ok}, {31'b0, eok});
    check(req, "corner code", {20'b0, direct_code}, {20'b0, ecode});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] x;
    rst = 1'b1; in_valid = 1'b0; in_word = '0; dec_code = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", "out_valid in reset", {31'b0, out_valid}, 32'h0);
    check("R8", "flags in reset", {30'b0, direct_ok, inv_ok}, 32'h0);
    rst = 1'b0;

    // Named corners (R1 code layout, R2, R3, R4, R5, R6)
    corner("R2", 32'h000000FF, 1'b1, 12'h0FF);
    corner("R2", 32'h000FF000, 1'b1, 12'hAFF);
    corner("R2", 32'hF000000F, 1'b1, 12'h2FF);
    corner("R1", 32'h0000F200, 1'b1, 12'hCF2);
    corner("R2", 32'h000003FC, 1'b1, 12'hFFF);
    corner("R1", 32'h00007F00, 1'b1, 12'hC7F);
    corner("R3", 32'h00000101, 1'b0, 12'h000);
    corner("R3", 32'h0000FF04, 1'b0, 12'h000);
    corner("R3", 32'h000001FE, 1'b0, 12'h000);
    corner("R3", 32'h000001FF, 1'b0, 12'h000);
    corner("R4", 32'h000003F0, 1'b1, 12'hE3F);
    corner("R5", 32'h00000000, 1'b1, 12'h000);
    run_one(32'hFFFFFF00, 12'h0FF);
    check("R6", "inv_ok for FFFFFF00", {31'b0, inv_ok}, 32'h1);
    check("R6", "inv_code for FFFFFF00", {20'b0, inv_code}, 32'h0FF);

    // Every code expanded and fed back, then its inverse.
    for (int c = 0; c < 4096; c++) run_one(ref_expand(c[11:0]), c[11:0]);
    for (int c = 0; c < 4096; c++) run_one(~ref_expand(c[11:0]), 12'hFFF - c[11:0]);

    // Random constants.
    x = 32'h1234_5679;
    for (int k = 0; k < 2000; k++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      run_one(x, x[23:12]);
    end

    // R7 no strobe: no valid pulse, results held
    in_valid = 1'b0; dec_code = 12'h4AB;
    @(negedge clk);
    check("R7", "out_valid idle", {31'b0, out_valid}, 32'h0);
    check("R10", "dec_word without strobe", dec_word, ref_expand(12'h4AB));

    // R8 reset while strobing
    run_one(32'h000000FF, 12'h0FF);
    rst = 1'b1; in_valid = 1'b1; in_word = 32'h0000F200;
    @(negedge clk);
    check("R8", "out_valid under reset", {31'b0, out_valid}, 32'h0);
    check("R8", "flags under reset", {30'b0, direct_ok, inv_ok}, 32'h0);
    check("R8", "code under reset", {20'b0, direct_code}, 32'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule